// File: doc/BRIEF.md
# Configurable Port Output Multiplexer

This block drives a small set of general-purpose output pins (two by default). Each pin has its own 3-bit function code, and the code picks what the pin carries. The choices are a square-wave tone at one of three frequencies, the serial data-out bit, the blink phase, the shutdown flag, or a static level set by the host. The tones are meant for driving a buzzer. The serial interface, the blink timer and the register file sit outside this block and deliver their results as plain input wires.

All tones come from one shared divider. A counter wraps every `HALF_CYC` oscillator cycles, 800 by default. Each wrap advances a 3-bit tick count, and bit i of that count is tone i. With a 4 MHz oscillator this gives 2500 Hz, 1250 Hz and 625 Hz, each with a 50% duty cycle.

Each pin is a flip-flop loaded from its selector. A change of function code or of a source therefore shows on the pin at the next clock edge. The only transition this adds is the one caused by the select change itself.

Top module: `port_out_mux`

## Requirements
- R1: While `rst` is high, every pin is low and the divider is cleared. After `rst` falls, tone 0 first rises at the `HALF_CYC`-th clock edge.
- R2: Code 3'b011 drives the pin with the fastest tone. That tone toggles once every `HALF_CYC` clock edges, so the duty cycle is 50% and the frequency is 2500 Hz at 4 MHz.
- R3: Code 3'b010 selects the tone at half the fastest frequency (1250 Hz). Code 3'b001 selects the tone at a quarter of it (625 Hz). Each slower tone toggles only when the next faster tone falls.
- R4: Code 3'b100 drives the pin with the serial data-out input `ser_dout`.
- R5: Code 3'b101 drives the pin with the blink phase input `blink_phase`.
- R6: Code 3'b110 drives the pin with the shutdown flag input `shdn_flag`.
- R7: Code 3'b000 drives the pin with the pin's own bit of `gpo_level`.
- R8: Code 3'b111 drives the pin low, whatever any source is doing.
- R9: Port p uses only bits [3p+2:3p] of `port_cfg` and bit p of `gpo_level`. A pin's value never depends on another port's code or level.
- R10: A pin shows its code and its sources as they stood at the previous rising clock edge, one cycle later and registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| port_cfg | input | 3*NUM_PORTS | Function code per port; port p uses bits [3p+2:3p] |
| gpo_level | input | NUM_PORTS | Static level per port, used with code 000 |
| ser_dout | input | 1 | Serial data-out bit from the serial interface |
| blink_phase | input | 1 | Blink phase from the blink timer |
| shdn_flag | input | 1 | Shutdown status |
| port_pin | output | NUM_PORTS | Output pins |

## Verification
Every pin result is due exactly one rising edge after its code and sources were presented. The tone value used at that edge is the divider state after the edges counted so far since reset. The bench drives inputs on the falling edge and computes the expected pin value at that moment. It uses the tone bits of (edges since reset / `HALF_CYC`) and compares at the following falling edge, so each check falls one full register stage after its stimulus. Reset is applied a second time in mid-run, which confirms that tone timing restarts from a cleared divider.

// File: rtl/port_out_mux_pkg.sv
package port_out_mux_pkg;

  localparam int FN_W   = 3;
  localparam int TONE_N = 3;

  typedef enum logic [FN_W-1:0] {
    FN_LEVEL    = 3'd0,
    FN_TONE_Q   = 3'd1,
    FN_TONE_H   = 3'd2,
    FN_TONE_F   = 3'd3,
    FN_SERIAL   = 3'd4,
    FN_BLINK    = 3'd5,
    FN_SHUTDOWN = 3'd6,
    FN_OFF      = 3'd7
  } port_fn_e;

  // Tone bit index for a tone code: the fastest tone is bit 0.
  function automatic int tone_index(port_fn_e fn);
    return TONE_N - int'(fn);
  endfunction

  // Level that a pin takes for a given function and source set.
  function automatic logic route_level(
    port_fn_e           fn,
    logic [TONE_N-1:0]  tones,
    logic               lvl,
    logic               dout,
    logic               blink,
    logic               shdn
  );
    logic r;
    case (fn)
      FN_LEVEL:    r = lvl;
      FN_TONE_Q:   r = tones[tone_index(FN_TONE_Q)];
      FN_TONE_H:   r = tones[tone_index(FN_TONE_H)];
      FN_TONE_F:   r = tones[tone_index(FN_TONE_F)];
      FN_SERIAL:   r = dout;
      FN_BLINK:    r = blink;
      FN_SHUTDOWN: r = shdn;
      default:     r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tone_divider.sv
module tone_divider #(
  parameter int HALF_CYC = 800,
  parameter int TONE_N   = 3
) (
  input  logic              clk,
  input  logic              rst,
  output logic [TONE_N-1:0] tones,
  output logic              wrap_tick
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0]     cnt_q;
  logic [TONE_N-1:0] tick_q;

  assign wrap_tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (wrap_tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  // Each stage toggles when the stage below it falls: a ripple-free binary count.
  genvar gi;
  generate
    for (gi = 0; gi < TONE_N; gi++) begin : g_stage
      logic adv;
      if (gi == 0) begin : g_first
        assign adv = wrap_tick;
      end else begin : g_next
        assign adv = wrap_tick & (&tick_q[gi-1:0]);
      end
      always_ff @(posedge clk) begin
        if (rst) begin
          tick_q[gi] <= 1'b0;
        end else if (adv) begin
          tick_q[gi] <= ~tick_q[gi];
        end
      end
    end
  endgenerate

  assign tones = tick_q;

  // R2: the fastest tone changes only at the end of a full count window
  a_r2_tone_on_wrap: assert property (@(posedge clk) disable iff (rst)
    !$stable(tick_q[0]) |-> ($past(cnt_q) == LAST));

  // R1: the counter restarts from zero after reset
  a_r1_count_cleared: assert property (@(posedge clk)
    rst |=> (cnt_q == '0) && (tick_q == '0));

  generate
    for (gi = 1; gi < TONE_N; gi++) begin : g_chk
      // R3: a slower tone moves only when the faster one falls
      a_r3_halving: assert property (@(posedge clk) disable iff (rst)
        !$stable(tick_q[gi]) |-> $fell(tick_q[gi-1]));
    end
  endgenerate
endmodule

// File: rtl/port_slice.sv
module port_slice
  import port_out_mux_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [FN_W-1:0]   fn_code,
  input  logic              lvl,
  input  logic [TONE_N-1:0] tones,
  input  logic              dout,
  input  logic              blink,
  input  logic              shdn,
  output logic              pin
);
  port_fn_e fn;
  logic     src_pick;

  assign fn       = port_fn_e'(fn_code);
  assign src_pick = route_level(fn, tones, lvl, dout, blink, shdn);

  always_ff @(posedge clk) begin
    if (rst) pin <= 1'b0;
    else     pin <= src_pick;
  end

  // R1: reset drives the pin low
  a_r1_pin_low: assert property (@(posedge clk) rst |=> !pin);

  // R7: host level reaches the pin one edge later
  a_r7_level: assert property (@(posedge clk) disable iff (rst)
    (fn_code == 3'd0) |=> (pin == $past(lvl)));

  // R4: serial data-out follows
  a_r4_serial: assert property (@(posedge clk) disable iff (rst)
    (fn_code == 3'd4) |=> (pin == $past(dout)));

  // R5: blink phase follows
  a_r5_blink: assert property (@(posedge clk) disable iff (rst)
    (fn_code == 3'd5) |=> (pin == $past(blink)));

  // R6: shutdown flag follows
  a_r6_shutdown: assert property (@(posedge clk) disable iff (rst)
    (fn_code == 3'd6) |=> (pin == $past(shdn)));

  // R8: the unused code forces the pin low
  a_r8_off_low: assert property (@(posedge clk) disable iff (rst)
    (fn_code == 3'd7) |=> !pin);

  // R2: the fastest tone code copies tone bit 0
  a_r2_fast_tone: assert property (@(posedge clk) disable iff (rst)
    (fn_code == 3'd3) |=> (pin == $past(tones[0])));
endmodule

// File: rtl/port_out_mux.sv
module port_out_mux
  import port_out_mux_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int HALF_CYC  = 800
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [FN_W*NUM_PORTS-1:0] port_cfg,
  input  logic [NUM_PORTS-1:0]      gpo_level,
  input  logic                      ser_dout,
  input  logic                      blink_phase,
  input  logic                      shdn_flag,
  output logic [NUM_PORTS-1:0]      port_pin
);
  logic [TONE_N-1:0] tone_bus;
  logic              div_wrap;

  tone_divider #(
    .HALF_CYC (HALF_CYC),
    .TONE_N   (TONE_N)
  ) u_div (
    .clk       (clk),
    .rst       (rst),
    .tones     (tone_bus),
    .wrap_tick (div_wrap)
  );

  genvar gp;
  generate
    for (gp = 0; gp < NUM_PORTS; gp++) begin : g_port
      port_slice u_slice (
        .clk     (clk),
        .rst     (rst),
        .fn_code (port_cfg[FN_W*gp +: FN_W]),
        .lvl     (gpo_level[gp]),
        .tones   (tone_bus),
        .dout    (ser_dout),
        .blink   (blink_phase),
        .shdn    (shdn_flag),
        .pin     (port_pin[gp])
      );
    end
  endgenerate

  // R2: the divider wraps only when the fastest tone is about to move
  a_r2_wrap_moves_tone: assert property (@(posedge clk) disable iff (rst)
    div_wrap |=> !$stable(tone_bus[0]));
endmodule

// File: tb/port_out_mux_tb_top.sv
module port_out_mux_tb_top;
  localparam int NP   = 2;
  localparam int HALF = 800;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [3*NP-1:0] port_cfg = '0;
  logic [NP-1:0]   gpo_level = '0;
  logic            ser_dout = 1'b0;
  logic            blink_phase = 1'b0;
  logic            shdn_flag = 1'b0;
  logic [NP-1:0]   port_pin;

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  int unsigned edges = 0;
  bit          done  = 0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (rst) edges <= 0;
    else     edges <= edges + 1;
  end

  port_out_mux #(.NUM_PORTS(NP), .HALF_CYC(HALF)) dut_i (
    .clk(clk), .rst(rst), .port_cfg(port_cfg), .gpo_level(gpo_level),
    .ser_dout(ser_dout), .blink_phase(blink_phase), .shdn_flag(shdn_flag),
    .port_pin(port_pin)
  );

  // Tone k (0 = fastest) after n edges since reset: bit k of n / HALF.
  function automatic bit tone_bit(int unsigned n, int k);
    int unsigned t = n / HALF;
    return bit'((t >> k) & 1);
  endfunction

  function automatic bit model_pin(logic [2:0] c, bit lvl, int unsigned n,
                                   bit d, bit b, bit s);
    if (c == 3'd0) return lvl;
    if (c == 3'd1) return tone_bit(n, 2);
    if (c == 3'd2) return tone_bit(n, 1);
    if (c == 3'd3) return tone_bit(n, 0);
    if (c == 3'd4) return d;
    if (c == 3'd5) return b;
    if (c == 3'd6) return s;
    return 1'b0;
  endfunction

  function automatic string req_of(logic [2:0] c);
    case (c)
      3'd0: return "R7";
      3'd1: return "R3";
      3'd2: return "R3";
      3'd3: return "R2";
      3'd4: return "R4";
      3'd5: return "R5";
      3'd6: return "R6";
      default: return "R8";
    endcase
  endfunction

  bit [NP-1:0] exp_pin;
  string       exp_tag [NP];

  task automatic compare_pins();
    for (int p = 0; p < NP; p++) begin
      n_cmp++;
      if (port_pin[p] !== exp_pin[p]) begin
        n_bad++;
        $display("FAIL %s port %0d edge %0d: got %b expected %b",
                 exp_tag[p], p, edges, port_pin[p], exp_pin[p]);
      end
    end
  endtask

  task automatic predict(bit changed);
    for (int p = 0; p < NP; p++) begin
      logic [2:0] c = port_cfg[3*p +: 3];
      exp_pin[p] = model_pin(c, gpo_level[p], edges, ser_dout, blink_phase, shdn_flag);
      exp_tag[p] = req_of(c);
      if (port_cfg[2:0] != port_cfg[5:3]) exp_tag[p] = {exp_tag[p], " R9"};
      if (changed) exp_tag[p] = {exp_tag[p], " R10"};
    end
  endtask

  task automatic random_run(int cycles, bit keep_fast);
    for (int i = 0; i < cycles; i++) begin
      bit chg = 0;
      @(negedge clk);
      compare_pins();
      if (!keep_fast && ($urandom % 8) == 0) begin
        port_cfg = 6'($urandom);
        chg = 1;
      end
      gpo_level   = 2'($urandom);
      ser_dout    = 1'($urandom);
      blink_phase = 1'($urandom);
      shdn_flag   = 1'($urandom);
      predict(chg);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1: pins low under reset
    n_cmp++;
    if (port_pin !== '0) begin
      n_bad++;
      $display("FAIL R1 reset: got %b expected 00", port_pin);
    end
    // R8 directed: code 7 with all sources high
    port_cfg = {3'd7, 3'd3}; gpo_level = '1; ser_dout = 1; blink_phase = 1; shdn_flag = 1;
    rst = 1'b0;
    predict(1);
    // R1 and R2: fastest tone stays low until HALF edges, then rises
    random_run(HALF + 20, 1);
    port_cfg = {3'd0, 3'd3};
    predict(1);
    random_run(14000, 0);
    // R1: mid-run reset must clear the divider
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    n_cmp++;
    if (port_pin !== '0) begin
      n_bad++;
      $display("FAIL R1 mid-run reset: got %b expected 00", port_pin);
    end
    port_cfg = {3'd1, 3'd3};
    rst = 1'b0;
    predict(1);
    random_run(7000, 1);
    random_run(12000, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 60000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule